// File: doc/BRIEF.md
# Address Quadrant Decode and Fault Reporter

This block sits beside a radix translation walker. For each access it decodes the two most significant bits of the effective address, the quadrant, into the partition and process identifiers that the walker needs. It also turns translation failures into an exception record. An address in a reserved quadrant raises a segment-class fault at once. A storage fault reported by the walker for a legal quadrant raises a storage-class fault. Each class splits by whether the access was an instruction fetch or a data access.

Instruction and data faults update different registers. A data fault captures the effective address. A data storage fault also captures a status word, which gets a store flag when the access was a write. An instruction storage fault places its cause bits in the error code. On every fault the block pulses an exception strobe for one cycle, and all the fault registers change on that same clock edge. Exception delivery to the pipeline and the walk itself are done elsewhere.

Top module: `quad_fault_unit`

## Requirements
- R1: In virtual mode with quadrant 0 (address bits [ADDR_W-1:ADDR_W-2] = 0), `selPartId` equals `partIdReg`, `selProcId` equals `procIdReg`, and `idValid` is 1. These outputs are combinational.
- R2: In virtual mode with quadrant 3, `selPartId` equals `partIdReg`, `selProcId` is 0, and `idValid` is 1.
- R3: A valid virtual-mode access in quadrant 1 or 2 raises a segment fault even when `storFault` is high. Meanwhile `idValid` is 0 and both selected IDs are 0.
- R4: A segment fault on a fetch sets `excCode` to 1 and `errCode` to 0. It leaves `dataAddr` and `dataStatus` unchanged.
- R5: A segment fault on a data access sets `excCode` to 2, loads `dataAddr` with the effective address, and clears `errCode`. It leaves `dataStatus` unchanged.
- R6: A storage fault on a fetch sets `excCode` to 3 and `errCode` to `faultCause`. It leaves `dataAddr` and `dataStatus` unchanged.
- R7: A storage fault on a data access sets `excCode` to 4, `dataStatus` to the cause, `dataAddr` to the effective address, and `errCode` to 0.
- R8: On a data storage fault caused by a write, bit STORE_BIT (default 25) is ORed into the cause before it is written to `dataStatus`. Reads do not set that bit.
- R9: `accessType` is encoded as 0 = read, 1 = write and 2 = fetch. The value 3 behaves exactly as a read.
- R10: `excStrobe` is high for exactly the one cycle after each faulting access. `excCode` and the other fault registers change only on that edge and hold their values until the next fault.
- R11: With `accessValid` low, or `virtMode` low (real mode), no fault is raised and no fault register changes. In real mode `idValid` is 0.
- R12: After reset, `excStrobe`, `excCode`, `dataAddr`, `dataStatus` and `errCode` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accessValid | input | 1 | An access is presented this cycle |
| accessType | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| virtMode | input | 1 | Translation enabled for this access |
| effAddr | input | ADDR_W | Effective address; top two bits are the quadrant |
| partIdReg | input | ID_W | Current partition identifier |
| procIdReg | input | ID_W | Current process identifier |
| storFault | input | 1 | Walker reports a storage fault for this access |
| faultCause | input | CAUSE_W | Cause bits from the walker |
| selPartId | output | ID_W | Selected partition identifier |
| selProcId | output | ID_W | Selected process identifier |
| idValid | output | 1 | The selected IDs are usable |
| excStrobe | output | 1 | One-cycle exception pulse |
| excCode | output | 3 | 0 none, 1 fetch segment, 2 data segment, 3 fetch storage, 4 data storage |
| dataAddr | output | ADDR_W | Captured faulting data address |
| dataStatus | output | CAUSE_W | Captured data fault status |
| errCode | output | CAUSE_W | Error code of the last fault |

## Verification
A misrouted fault class in the control shows up in the very next cycle: `excCode` is wrong, or the wrong capture register moves while one that should move holds. A stale or missing load is caught the same way, because every fault record is compared one edge after its access, and again after an idle cycle to confirm it holds. A wrong quadrant decode appears without delay on the combinational ID outputs, and on the choice between a segment fault and a storage fault.

// File: rtl/qfu_pkg.sv
package qfu_pkg;

  typedef enum logic [2:0] {
    EXC_NONE  = 3'd0,
    EXC_ISEG  = 3'd1,
    EXC_DSEG  = 3'd2,
    EXC_ISTOR = 3'd3,
    EXC_DSTOR = 3'd4
  } excCode_e;

  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  typedef struct packed {
    logic     fire;
    logic     ldAddr;
    logic     ldStatus;
    logic     errFromCause;
    logic     setStore;
    excCode_e code;
  } ctrlStrobes_t;

endpackage

// File: rtl/qfu_ctrl.sv
module qfu_ctrl
  import qfu_pkg::*;
#(
  parameter int ID_W = 32
) (
  input  logic [1:0]    quadrant,
  input  logic          accessValid,
  input  logic [1:0]    accessType,
  input  logic          virtMode,
  input  logic          storFault,
  input  logic [ID_W-1:0] partIdReg,
  input  logic [ID_W-1:0] procIdReg,
  output logic [ID_W-1:0] selPartId,
  output logic [ID_W-1:0] selProcId,
  output logic          idValid,
  output ctrlStrobes_t  strobes
);

  logic isFetch;
  logic isStore;
  logic legalQuad;
  logic segFault;
  logic stoFault;

  assign isFetch   = (accessType == ACC_FETCH);
  assign isStore   = (accessType == ACC_WRITE);
  assign legalQuad = (quadrant == 2'd0) || (quadrant == 2'd3);
  assign segFault  = accessValid && virtMode && !legalQuad;
  assign stoFault  = accessValid && virtMode && legalQuad && storFault;

  always_comb begin
    idValid   = virtMode && legalQuad;
    selPartId = idValid ? partIdReg : '0;
    selProcId = (virtMode && quadrant == 2'd0) ? procIdReg : '0;
  end

  always_comb begin
    strobes = '0;
    strobes.code = EXC_NONE;
    if (segFault) begin
      strobes.fire   = 1'b1;
      strobes.code   = isFetch ? EXC_ISEG : EXC_DSEG;
      strobes.ldAddr = !isFetch;
    end else if (stoFault) begin
      strobes.fire = 1'b1;
      if (isFetch) begin
        strobes.code         = EXC_ISTOR;
        strobes.errFromCause = 1'b1;
      end else begin
        strobes.code     = EXC_DSTOR;
        strobes.ldAddr   = 1'b1;
        strobes.ldStatus = 1'b1;
        strobes.setStore = isStore;
      end
    end
  end

endmodule

// File: rtl/qfu_dpath.sv
module qfu_dpath
  import qfu_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int CAUSE_W   = 32,
  parameter int STORE_BIT = 25
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [ADDR_W-1:0]  effAddr,
  input  logic [CAUSE_W-1:0] faultCause,
  output logic               excStrobe,
  output logic [2:0]         excCode,
  output logic [ADDR_W-1:0]  dataAddr,
  output logic [CAUSE_W-1:0] dataStatus,
  output logic [CAUSE_W-1:0] errCode
);

  localparam logic [CAUSE_W-1:0] STORE_MASK = CAUSE_W'(1) << STORE_BIT;

  logic [CAUSE_W-1:0] statusNext;
  assign statusNext = faultCause | (strobes.setStore ? STORE_MASK : '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      excStrobe  <= 1'b0;
      excCode    <= 3'd0;
      dataAddr   <= '0;
      dataStatus <= '0;
      errCode    <= '0;
    end else begin
      excStrobe <= strobes.fire;
      if (strobes.fire) begin
        excCode <= strobes.code;
        errCode <= strobes.errFromCause ? faultCause : '0;
      end
      if (strobes.ldAddr)   dataAddr   <= effAddr;
      if (strobes.ldStatus) dataStatus <= statusNext;
    end
  end

endmodule

// File: rtl/quad_fault_unit.sv
module quad_fault_unit
  import qfu_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int ID_W      = 32,
  parameter int CAUSE_W   = 32,
  parameter int STORE_BIT = 25
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               accessValid,
  input  logic [1:0]         accessType,
  input  logic               virtMode,
  input  logic [ADDR_W-1:0]  effAddr,
  input  logic [ID_W-1:0]    partIdReg,
  input  logic [ID_W-1:0]    procIdReg,
  input  logic               storFault,
  input  logic [CAUSE_W-1:0] faultCause,
  output logic [ID_W-1:0]    selPartId,
  output logic [ID_W-1:0]    selProcId,
  output logic               idValid,
  output logic               excStrobe,
  output logic [2:0]         excCode,
  output logic [ADDR_W-1:0]  dataAddr,
  output logic [CAUSE_W-1:0] dataStatus,
  output logic [CAUSE_W-1:0] errCode
);

  ctrlStrobes_t strobes;

  qfu_ctrl #(.ID_W(ID_W)) u_ctrl (
    .quadrant   (effAddr[ADDR_W-1 -: 2]),
    .accessValid(accessValid),
    .accessType (accessType),
    .virtMode   (virtMode),
    .storFault  (storFault),
    .partIdReg  (partIdReg),
    .procIdReg  (procIdReg),
    .selPartId  (selPartId),
    .selProcId  (selProcId),
    .idValid    (idValid),
    .strobes    (strobes)
  );

  qfu_dpath #(.ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W), .STORE_BIT(STORE_BIT)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .effAddr   (effAddr),
    .faultCause(faultCause),
    .excStrobe (excStrobe),
    .excCode   (excCode),
    .dataAddr  (dataAddr),
    .dataStatus(dataStatus),
    .errCode   (errCode)
  );

endmodule

// File: rtl/qfu_checker.sv
module qfu_checker #(
  parameter int ADDR_W    = 64,
  parameter int ID_W      = 32,
  parameter int CAUSE_W   = 32,
  parameter int STORE_BIT = 25
) (
  input logic               clk,
  input logic               rstN,
  input logic               accessValid,
  input logic [1:0]         accessType,
  input logic               virtMode,
  input logic [ADDR_W-1:0]  effAddr,
  input logic [ID_W-1:0]    partIdReg,
  input logic [ID_W-1:0]    procIdReg,
  input logic               storFault,
  input logic [CAUSE_W-1:0] faultCause,
  input logic [ID_W-1:0]    selPartId,
  input logic [ID_W-1:0]    selProcId,
  input logic               idValid,
  input logic               excStrobe,
  input logic [2:0]         excCode,
  input logic [ADDR_W-1:0]  dataAddr,
  input logic [CAUSE_W-1:0] dataStatus,
  input logic [CAUSE_W-1:0] errCode
);

  logic [1:0] quad;
  assign quad = effAddr[ADDR_W-1 -: 2];

  p_quad0_ids_r1: assert property (@(posedge clk) disable iff (!rstN)
    (virtMode && quad == 2'd0) |-> (selPartId == partIdReg && selProcId == procIdReg && idValid));

  p_quad3_pid_r2: assert property (@(posedge clk) disable iff (!rstN)
    (virtMode && quad == 2'd3) |-> (selProcId == '0 && selPartId == partIdReg));

  p_seg_illegal_r3: assert property (@(posedge clk) disable iff (!rstN)
    (accessValid && virtMode && (quad == 2'd1 || quad == 2'd2))
      |=> (excStrobe && (excCode == 3'd1 || excCode == 3'd2)));

  p_fetch_seg_addr_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (excStrobe && excCode == 3'd1) |-> ($stable(dataAddr) && $stable(dataStatus) && errCode == '0));

  p_data_err_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (excStrobe && (excCode == 3'd2 || excCode == 3'd4)) |-> (errCode == '0));

  p_store_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (accessValid && virtMode && storFault && accessType == 2'd1 && (quad == 2'd0 || quad == 2'd3))
      |=> dataStatus[STORE_BIT]);

  p_no_fault_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(accessValid && virtMode) |=> (!excStrobe && $stable(excCode) && $stable(dataAddr)
                                    && $stable(dataStatus) && $stable(errCode)));

  p_strobe_code_r10: assert property (@(posedge clk) disable iff (!rstN)
    excStrobe |-> (excCode != 3'd0));

  logic unusedSink;
  assign unusedSink = ^{faultCause, procIdReg};

endmodule

bind quad_fault_unit qfu_checker #(
  .ADDR_W(ADDR_W), .ID_W(ID_W), .CAUSE_W(CAUSE_W), .STORE_BIT(STORE_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .accessValid(accessValid), .accessType(accessType),
  .virtMode(virtMode), .effAddr(effAddr), .partIdReg(partIdReg), .procIdReg(procIdReg),
  .storFault(storFault), .faultCause(faultCause), .selPartId(selPartId),
  .selProcId(selProcId), .idValid(idValid), .excStrobe(excStrobe), .excCode(excCode),
  .dataAddr(dataAddr), .dataStatus(dataStatus), .errCode(errCode)
);

// File: tb/quad_fault_unit_test.sv
module quad_fault_unit_test;

  localparam int ADDR_W = 64;
  localparam int ID_W = 32;
  localparam int CAUSE_W = 32;
  localparam int STORE_BIT = 25;
  localparam int NVEC = 14;

  // {valid, virt, atype[1:0], quad[1:0], storF, expStrobe, expCode[2:0]}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0},  // R1 quadrant 0 read, no fault
    {1'b1, 1'b1, 2'd0, 2'd1, 1'b0, 1'b1, 3'd2},  // R5 data segment
    {1'b1, 1'b1, 2'd2, 2'd2, 1'b0, 1'b1, 3'd1},  // R4 fetch segment
    {1'b1, 1'b1, 2'd1, 2'd2, 1'b1, 1'b1, 3'd2},  // R3 segment beats storage
    {1'b1, 1'b1, 2'd0, 2'd0, 1'b1, 1'b1, 3'd4},  // R7 data storage read
    {1'b1, 1'b1, 2'd1, 2'd3, 1'b1, 1'b1, 3'd4},  // R8 data storage write
    {1'b1, 1'b1, 2'd2, 2'd0, 1'b1, 1'b1, 3'd3},  // R6 fetch storage
    {1'b1, 1'b1, 2'd3, 2'd3, 1'b1, 1'b1, 3'd4},  // R9 type 3 acts as read
    {1'b1, 1'b0, 2'd0, 2'd1, 1'b1, 1'b0, 3'd0},  // R11 real mode
    {1'b0, 1'b1, 2'd1, 2'd2, 1'b1, 1'b0, 3'd0},  // R11 not valid
    {1'b1, 1'b1, 2'd2, 2'd1, 1'b0, 1'b1, 3'd1},  // R4 fetch segment q1
    {1'b1, 1'b1, 2'd1, 2'd0, 1'b1, 1'b1, 3'd4},  // R8 store in quadrant 0
    {1'b1, 1'b0, 2'd2, 2'd2, 1'b1, 1'b0, 3'd0},  // R11 real mode fetch
    {1'b1, 1'b1, 2'd3, 2'd1, 1'b0, 1'b1, 3'd2}   // R9 type 3 data segment
  };

  logic clk = 1'b0;
  logic rstN;
  logic accessValid;
  logic [1:0] accessType;
  logic virtMode;
  logic [ADDR_W-1:0] effAddr;
  logic [ID_W-1:0] partIdReg;
  logic [ID_W-1:0] procIdReg;
  logic storFault;
  logic [CAUSE_W-1:0] faultCause;
  logic [ID_W-1:0] selPartId;
  logic [ID_W-1:0] selProcId;
  logic idValid;
  logic excStrobe;
  logic [2:0] excCode;
  logic [ADDR_W-1:0] dataAddr;
  logic [CAUSE_W-1:0] dataStatus;
  logic [CAUSE_W-1:0] errCode;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [2:0] eCode;
  logic [ADDR_W-1:0] eAddr;
  logic [CAUSE_W-1:0] eStatus;
  logic [CAUSE_W-1:0] eErr;

  always #5 clk = ~clk;

  quad_fault_unit #(.ADDR_W(ADDR_W), .ID_W(ID_W), .CAUSE_W(CAUSE_W), .STORE_BIT(STORE_BIT)) uut (
    .clk(clk), .rstN(rstN), .accessValid(accessValid), .accessType(accessType),
    .virtMode(virtMode), .effAddr(effAddr), .partIdReg(partIdReg), .procIdReg(procIdReg),
    .storFault(storFault), .faultCause(faultCause), .selPartId(selPartId),
    .selProcId(selProcId), .idValid(idValid), .excStrobe(excStrobe), .excCode(excCode),
    .dataAddr(dataAddr), .dataStatus(dataStatus), .errCode(errCode)
  );

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkRecord(input string req, input logic expStrobe);
    check(req, "excStrobe", 64'(excStrobe), 64'(expStrobe));
    check(req, "excCode", 64'(excCode), 64'(eCode));
    check(req, "dataAddr", 64'(dataAddr), 64'(eAddr));
    check(req, "dataStatus", 64'(dataStatus), 64'(eStatus));
    check(req, "errCode", 64'(errCode), 64'(eErr));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    accessValid = 1'b0;
    accessType = 2'd0;
    virtMode = 1'b0;
    effAddr = '0;
    partIdReg = 32'h0000_0A5C;
    procIdReg = 32'h0001_2345;
    storFault = 1'b0;
    faultCause = '0;
    eCode = 3'd0;
    eAddr = '0;
    eStatus = '0;
    eErr = '0;
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    checkRecord("R12", 1'b0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [10:0] v;
      logic [ADDR_W-1:0] addr;
      logic [CAUSE_W-1:0] cause;
      v = VEC[i];
      addr = {v[6:5], 62'h0123_4567_89AB_0000 + 62'(i * 16'h111)};
      cause = 32'h4000_0000 | (32'(i) << 4);
      @(negedge clk);
      accessValid = v[10];
      virtMode = v[9];
      accessType = v[8:7];
      effAddr = addr;
      storFault = v[4];
      faultCause = cause;
      if (v[3]) begin
        eCode = v[2:0];
        case (v[2:0])
          3'd1: eErr = '0;
          3'd2: begin eAddr = addr; eErr = '0; end
          3'd3: eErr = cause;
          3'd4: begin
            eAddr = addr;
            eErr = '0;
            eStatus = cause | ((v[8:7] == 2'd1) ? (32'd1 << STORE_BIT) : 32'd0);
          end
          default: ;
        endcase
      end
      @(posedge clk);
      #1;
      checkRecord($sformatf("R10 vec%0d", i), v[3]);
    end

    // R10: strobe drops after one cycle and the record holds
    @(negedge clk);
    accessValid = 1'b0;
    @(posedge clk);
    #1;
    checkRecord("R10 hold", 1'b0);

    // R1: quadrant 0 IDs
    @(negedge clk);
    virtMode = 1'b1;
    effAddr = {2'd0, 62'h55};
    #1;
    check("R1", "selPartId", 64'(selPartId), 64'(partIdReg));
    check("R1", "selProcId", 64'(selProcId), 64'(procIdReg));
    check("R1", "idValid", 64'(idValid), 64'd1);

    // R2: quadrant 3 forces process ID to zero
    effAddr = {2'd3, 62'h55};
    #1;
    check("R2", "selPartId", 64'(selPartId), 64'(partIdReg));
    check("R2", "selProcId", 64'(selProcId), 64'd0);
    check("R2", "idValid", 64'(idValid), 64'd1);

    // R3: illegal quadrant gives no IDs
    effAddr = {2'd2, 62'h55};
    #1;
    check("R3", "idValid", 64'(idValid), 64'd0);
    check("R3", "selPartId", 64'(selPartId), 64'd0);
    check("R3", "selProcId", 64'(selProcId), 64'd0);

    // R11: real mode gives no IDs
    virtMode = 1'b0;
    effAddr = {2'd0, 62'h55};
    #1;
    check("R11", "idValid", 64'(idValid), 64'd0);

    // R10: back-to-back faults each pulse the strobe
    @(negedge clk);
    virtMode = 1'b1;
    accessValid = 1'b1;
    accessType = 2'd0;
    effAddr = {2'd1, 62'h777};
    eCode = 3'd2; eAddr = effAddr; eErr = '0;
    @(posedge clk);
    #1;
    checkRecord("R10 b2b first", 1'b1);
    @(negedge clk);
    accessType = 2'd2;
    effAddr = {2'd3, 62'h999};
    storFault = 1'b1;
    faultCause = 32'h0000_0F0F;
    eCode = 3'd3; eErr = 32'h0000_0F0F;
    @(posedge clk);
    #1;
    checkRecord("R6 b2b second", 1'b1);
    @(negedge clk);
    accessValid = 1'b0;
    @(posedge clk);
    #1;
    checkRecord("R10 b2b end", 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule